// File: doc/BRIEF.md
# I2C Transaction Command Sequencer

This block sits between a message-level request interface and a bit-level I2C engine that consumes a stream of 16-bit command words. For each request (7-bit target address, direction, byte count, restart flag, stop flag, last-of-transaction flag) it emits bus-condition bursts (start, repeated start, stop), the address word, one command word per data byte, and it gathers the bytes the engine shifts back in. Bus-condition bursts travel in the same command stream as data. An escape word carries a primitive count n in bits 15:10, and the next n+1 words are primitives. A primitive word uses bit 0 for SDA released, bit 1 for SCL released and bit 2 for "wait until SCL reads high". All other words have bits 15:10 zero. In those words bit 9 marks the final byte, so the engine does not flag a NAK on it, bits 8:1 hold the byte and bit 0 is the level driven in the acknowledge slot (1 = released).

The engine reports a sticky NAK error, an empty-and-idle indication, and received bytes. After each message the sequencer waits until the engine is drained or in error. On error it pulses a recovery request, issues a stop, and reports the transaction as failed. Any remaining messages of that transaction are then swallowed.

Top module: `i2c_cmd_seq`

## Requirements
- R1: A message opens with a start only when the previous message ended with a stop (true after reset) and its restart flag is clear. The start is the words 16'h0400, 16'h0002, 16'h0000.
- R2: A message with the restart flag opens with a repeated start: 16'h1000, 16'h0001, 16'h0003, 16'h0004, 16'h0002, 16'h0000.
- R3: A stop (16'h0C00, 16'h0000, 16'h0002, 16'h0004, 16'h0003) follows the data of a message whose stop flag or last flag is set. A message that ends without a stop makes the next message without restart emit neither a start nor an address word.
- R4: Right after a start or repeated start, the address word {7'b0, addr[6:0], read, 1'b1} is emitted.
- R5: A write emits one word {7'b0, byte, 1'b1} per byte taken from the write-data stream, in order.
- R6: A read of N bytes emits N-1 words 16'h01FE, then 16'h03FF for the last byte.
- R7: Before a read, receive capture is enabled and stale received bytes are popped and dropped. When the read began with a start, the first received byte (the address echo) is dropped. Exactly N bytes are then delivered in order on rd_valid/rd_data.
- R8: When the engine flags an error, the sequencer pulses eng_recover once and then emits a stop burst. If that message was the last of the transaction, done and done_err pulse together.
- R9: After an error in a non-final message, every later message up to and including the last is accepted without any command word; its write bytes are consumed, and done with done_err pulses at the last one.
- R10: After reset, req_ready is high and cmd_valid, done and rx_en are low. A transaction that succeeds ends with one done pulse with done_err low.
- R11: While eng_err is high, no command word is offered. An offered word that is not accepted stays unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Message request valid |
| req_ready | output | 1 | Sequencer can accept a request |
| req_addr | input | 7 | Target address |
| req_read | input | 1 | 1 = read message |
| req_len | input | LEN_W | Byte count |
| req_restart | input | 1 | Open with a repeated start |
| req_stop | input | 1 | Close with a stop |
| req_last | input | 1 | Last message of the transaction (implicit stop) |
| wr_valid | input | 1 | Write byte available |
| wr_ready | output | 1 | Write byte taken |
| wr_data | input | 8 | Write byte |
| cmd_valid | output | 1 | Command word offered to the engine |
| cmd_ready | input | 1 | Engine command FIFO has room |
| cmd_word | output | 16 | Command word |
| eng_err | input | 1 | Engine NAK error flag (sticky) |
| eng_tx_empty | input | 1 | Engine command FIFO empty and idle |
| eng_recover | output | 1 | Engine restart and error clear request |
| rx_en | output | 1 | Enable engine receive capture |
| eng_rx_valid | input | 1 | Received byte available |
| eng_rx_ready | output | 1 | Pop received byte |
| eng_rx_data | input | 8 | Received byte |
| rd_valid | output | 1 | Read data byte strobe |
| rd_data | output | 8 | Read data byte |
| done | output | 1 | Transaction finished |
| done_err | output | 1 | Transaction failed (with done) |

## Verification
The bench drives the sequencer against a behavioural engine that executes escape counts, echoes bytes and can NAK a chosen word. It targets a stale byte left in the receive queue, a write followed by a restarted read, and two messages joined without a stop. It also injects a NAK both in the middle of a write and on the address of the final message. A design that skipped the drain or the echo drop would return shifted read data. One that always emitted a start would put a start and an address word between joined messages. A design that pushed during an error or failed to swallow the aborted message would leave stray data words in the stream or stall the write-data stream.

// File: rtl/i2c_cmd_seq.sv
module i2c_cmd_seq #(
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [6:0]       req_addr,
  input  logic             req_read,
  input  logic [LEN_W-1:0] req_len,
  input  logic             req_restart,
  input  logic             req_stop,
  input  logic             req_last,
  input  logic             wr_valid,
  output logic             wr_ready,
  input  logic [7:0]       wr_data,
  output logic             cmd_valid,
  input  logic             cmd_ready,
  output logic [15:0]      cmd_word,
  input  logic             eng_err,
  input  logic             eng_tx_empty,
  output logic             eng_recover,
  output logic             rx_en,
  input  logic             eng_rx_valid,
  output logic             eng_rx_ready,
  input  logic [7:0]       eng_rx_data,
  output logic             rd_valid,
  output logic [7:0]       rd_data,
  output logic             done,
  output logic             done_err
);

  localparam logic [15:0] ESC_START = 16'(1) << 10;
  localparam logic [15:0] ESC_STOP  = 16'(3) << 10;
  localparam logic [15:0] ESC_REP   = 16'(4) << 10;
  localparam logic [15:0] P_LL = 16'h0000;
  localparam logic [15:0] P_LH = 16'h0001;
  localparam logic [15:0] P_HL = 16'h0002;
  localparam logic [15:0] P_HH = 16'h0003;
  localparam logic [15:0] P_WT = 16'h0004;
  localparam logic [15:0] RD_MORE = 16'h01FE;
  localparam logic [15:0] RD_LAST = 16'h03FF;
  localparam logic [LEN_W-1:0] ONE = LEN_W'(1);

  typedef enum logic [3:0] {
    S_IDLE, S_DRAIN, S_START, S_ADDR, S_DATA, S_STOP, S_WAIT, S_RECOV, S_RSTOP, S_SKIP
  } st_t;

  st_t              st;
  logic [2:0]       idx;
  logic [LEN_W-1:0] cnt;
  logic [LEN_W:0]   rx_left;
  logic             rx_skip, rep, started, is_rd, do_stop, is_last, prev_stop, abort;
  logic [6:0]       addr_q;

  logic emit, have, step, burst_end, rx_pop, start_n;
  st_t  after_data;

  assign start_n    = req_restart | prev_stop;
  assign req_ready  = (st == S_IDLE);
  assign emit       = (st == S_START) || (st == S_ADDR) || (st == S_DATA) ||
                      (st == S_STOP) || (st == S_RSTOP);
  assign have       = !(st == S_DATA && !is_rd) || wr_valid;
  assign cmd_valid  = emit && have && !eng_err;
  assign step       = emit && have && (cmd_ready || eng_err);
  assign wr_ready   = (st == S_SKIP) || (st == S_DATA && !is_rd && step);
  assign burst_end  = (st == S_START) ? (idx == (rep ? 3'd5 : 3'd2)) : (idx == 3'd4);
  assign after_data = do_stop ? S_STOP : S_WAIT;
  assign eng_recover  = (st == S_RECOV);
  assign eng_rx_ready = (st == S_DRAIN) || (st != S_IDLE && rx_left != '0);
  assign rx_pop       = eng_rx_valid && st != S_DRAIN && st != S_IDLE && rx_left != '0;

  always_comb begin
    cmd_word = P_LL;
    case (st)
      S_START:
        if (rep) begin
          case (idx)
            3'd0:    cmd_word = ESC_REP;
            3'd1:    cmd_word = P_LH;
            3'd2:    cmd_word = P_HH;
            3'd3:    cmd_word = P_WT;
            3'd4:    cmd_word = P_HL;
            default: cmd_word = P_LL;
          endcase
        end else begin
          case (idx)
            3'd0:    cmd_word = ESC_START;
            3'd1:    cmd_word = P_HL;
            default: cmd_word = P_LL;
          endcase
        end
      S_STOP, S_RSTOP:
        case (idx)
          3'd0:    cmd_word = ESC_STOP;
          3'd1:    cmd_word = P_LL;
          3'd2:    cmd_word = P_HL;
          3'd3:    cmd_word = P_WT;
          default: cmd_word = P_HH;
        endcase
      S_ADDR:  cmd_word = {7'b0, addr_q, is_rd, 1'b1};
      S_DATA:  cmd_word = is_rd ? ((cnt == ONE) ? RD_LAST : RD_MORE) : {7'b0, wr_data, 1'b1};
      default: cmd_word = P_LL;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; idx <= '0; cnt <= '0; rx_left <= '0; rx_skip <= 1'b0;
      rep <= 1'b0; started <= 1'b0; is_rd <= 1'b0; do_stop <= 1'b0; is_last <= 1'b0;
      addr_q <= '0; prev_stop <= 1'b1; abort <= 1'b0; rx_en <= 1'b0;
      rd_valid <= 1'b0; rd_data <= '0; done <= 1'b0; done_err <= 1'b0;
    end else begin
      rd_valid <= 1'b0;
      done     <= 1'b0;
      done_err <= 1'b0;
      if (rx_pop) begin
        rx_left <= rx_left - (LEN_W+1)'(1);
        if (rx_skip) rx_skip <= 1'b0;
        else begin
          rd_valid <= 1'b1;
          rd_data  <= eng_rx_data;
        end
      end
      if (step && (st == S_START || st == S_STOP || st == S_RSTOP)) idx <= idx + 3'd1;
      if (step && st == S_DATA) cnt <= cnt - ONE;
      case (st)
        S_IDLE:
          if (req_valid) begin
            addr_q  <= req_addr;
            is_rd   <= req_read;
            rx_en   <= req_read;
            do_stop <= req_stop | req_last;
            is_last <= req_last;
            cnt     <= req_len;
            idx     <= '0;
            if (abort) begin
              if (!req_read && req_len != '0) st <= S_SKIP;
              else if (req_last) begin
                done <= 1'b1; done_err <= 1'b1; abort <= 1'b0;
              end
            end else begin
              started <= start_n;
              rep     <= req_restart;
              rx_skip <= start_n;
              rx_left <= req_read ? ({1'b0, req_len} + (LEN_W+1)'(start_n)) : '0;
              if (req_read)            st <= S_DRAIN;
              else if (start_n)        st <= S_START;
              else if (req_len != '0)  st <= S_DATA;
              else                     st <= (req_stop | req_last) ? S_STOP : S_WAIT;
            end
          end
        S_DRAIN:
          if (!eng_rx_valid) st <= started ? S_START : ((cnt != '0) ? S_DATA : after_data);
        S_START:
          if (step && burst_end) begin
            idx <= '0;
            st  <= S_ADDR;
          end
        S_ADDR:
          if (step) st <= (cnt != '0) ? S_DATA : after_data;
        S_DATA:
          if (step && cnt == ONE) st <= after_data;
        S_STOP:
          if (step && burst_end) begin
            idx <= '0;
            st  <= S_WAIT;
          end
        S_WAIT:
          if (eng_err) st <= S_RECOV;
          else if (eng_tx_empty && rx_left == '0) begin
            prev_stop <= do_stop;
            st        <= S_IDLE;
            if (is_last) done <= 1'b1;
          end
        S_RECOV: begin
          rx_left <= '0;
          rx_skip <= 1'b0;
          st      <= S_RSTOP;
        end
        S_RSTOP:
          if (step && burst_end) begin
            idx       <= '0;
            prev_stop <= 1'b1;
            st        <= S_IDLE;
            if (is_last) begin
              done <= 1'b1; done_err <= 1'b1;
            end else abort <= 1'b1;
          end
        S_SKIP:
          if (wr_valid) begin
            cnt <= cnt - ONE;
            if (cnt == ONE) begin
              st <= S_IDLE;
              if (is_last) begin
                done <= 1'b1; done_err <= 1'b1; abort <= 1'b0;
              end
            end
          end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R11: an offered word waits unchanged unless an error withdraws it
  p_word_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready && !eng_err) |=> (eng_err || (cmd_valid && $stable(cmd_word))));

  // R7: every delivered byte was popped from the engine one cycle earlier
  p_rd_from_pop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(eng_rx_valid && eng_rx_ready));

  // R8: recovery is requested only after the engine showed an error
  p_recover_after_err_r8: assert property (@(posedge clk) disable iff (!rst_n)
    eng_recover |-> $past(eng_err));

  // R10: failure status only ever accompanies the completion pulse
  p_err_with_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done_err |-> done);

  // R5: write bytes are never taken while receive capture is on
  p_wr_pop_write_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ready |-> !rx_en);

endmodule

// File: tb/i2c_cmd_seq_bench.sv
`timescale 1ns/1ps
module i2c_cmd_seq_bench;
  localparam int LW = 8;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n;
  logic req_valid, req_ready, req_read, req_restart, req_stop, req_last;
  logic [6:0] req_addr;
  logic [LW-1:0] req_len;
  logic wr_valid, wr_ready;
  logic [7:0] wr_data;
  logic cmd_valid, cmd_ready;
  logic [15:0] cmd_word;
  logic eng_err, eng_tx_empty, eng_recover, rx_en;
  logic eng_rx_valid, eng_rx_ready;
  logic [7:0] eng_rx_data;
  logic rd_valid, done, done_err;
  logic [7:0] rd_data;

  i2c_cmd_seq #(.LEN_W(LW)) u_i2c_cmd_seq (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr), .req_read(req_read),
    .req_len(req_len), .req_restart(req_restart), .req_stop(req_stop), .req_last(req_last),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_word(cmd_word),
    .eng_err(eng_err), .eng_tx_empty(eng_tx_empty), .eng_recover(eng_recover), .rx_en(rx_en),
    .eng_rx_valid(eng_rx_valid), .eng_rx_ready(eng_rx_ready), .eng_rx_data(eng_rx_data),
    .rd_valid(rd_valid), .rd_data(rd_data), .done(done), .done_err(done_err)
  );

  // behavioural engine
  logic [15:0] cmdlog [0:1023];
  logic [7:0]  rxq [0:255];
  logic [7:0]  wbuf [0:63];
  logic [7:0]  rbuf [0:63];
  int wp, xp, prim_left, dw, nak_at, rxw, rxr, wptr, wcnt, rcnt, rec_cnt, viol;
  logic inject;
  int tests, fails;

  assign cmd_ready    = (wp - xp) < 4;
  assign eng_tx_empty = (xp == wp);
  assign eng_rx_valid = rxr < rxw;
  assign eng_rx_data  = rxq[rxr[7:0]];
  assign wr_valid     = wptr < wcnt;
  assign wr_data      = wbuf[wptr[5:0]];

  always @(posedge clk) begin
    logic [15:0] w;
    logic [7:0]  b;
    if (!rst_n) begin
      wp <= 0; xp <= 0; prim_left <= 0; dw <= 0; rxw <= 0; rxr <= 0;
      wptr <= 0; rcnt <= 0; rec_cnt <= 0; viol <= 0; eng_err <= 1'b0;
    end else begin
      if (cmd_valid && cmd_ready) begin
        cmdlog[wp] <= cmd_word;
        wp <= wp + 1;
      end
      if (inject) begin
        rxq[rxw[7:0]] <= 8'h5A;
        rxw <= rxw + 1;
      end
      if (eng_recover) begin
        eng_err <= 1'b0;
        xp <= wp;
        prim_left <= 0;
      end else if (!eng_err && xp < wp) begin
        w = cmdlog[xp];
        xp <= xp + 1;
        if (prim_left > 0) prim_left <= prim_left - 1;
        else if (w[15:10] != 6'd0) prim_left <= int'(w[15:10]) + 1;
        else begin
          b = (w[8:1] == 8'hFF) ? 8'(8'h30 + dw) : w[8:1];
          dw <= dw + 1;
          if (rx_en) begin
            rxq[rxw[7:0]] <= b;
            rxw <= rxw + 1;
          end
          if (dw == nak_at && !w[9]) eng_err <= 1'b1;
        end
      end
      if (eng_rx_ready && eng_rx_valid) rxr <= rxr + 1;
      if (wr_valid && wr_ready) wptr <= wptr + 1;
      if (eng_recover) rec_cnt <= rec_cnt + 1;
      if (cmd_valid && eng_err) viol <= viol + 1;
      if (rd_valid) begin
        rbuf[rcnt[5:0]] <= rd_data;
        rcnt <= rcnt + 1;
      end
    end
  end

  // expected command stream
  logic [15:0] exp_w [0:63];
  int en;

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, expv);
    end
  endtask

  task automatic add(input logic [15:0] w);
    exp_w[en] = w;
    en++;
  endtask
  task automatic add_start();
    add(16'h0400); add(16'h0002); add(16'h0000);
  endtask
  task automatic add_rep();
    add(16'h1000); add(16'h0001); add(16'h0003); add(16'h0004); add(16'h0002); add(16'h0000);
  endtask
  task automatic add_stop();
    add(16'h0C00); add(16'h0000); add(16'h0002); add(16'h0004); add(16'h0003);
  endtask
  function automatic logic [15:0] aw(input logic [6:0] a, input logic r);
    return {7'b0, a, r, 1'b1};
  endfunction

  task automatic cmp_log(input string tag, input int base);
    chk((wp - base) == en, tag, "word count", wp - base, en);
    for (int i = 0; i < en; i++)
      chk(cmdlog[base + i] === exp_w[i], tag, $sformatf("word %0d", i), int'(cmdlog[base + i]), int'(exp_w[i]));
  endtask

  task automatic put_wr(input logic [7:0] b);
    wbuf[wcnt[5:0]] = b;
    wcnt++;
  endtask

  task automatic send_req(input logic [6:0] a, input logic r, input int len,
                          input logic rs, input logic sp, input logic ls);
    @(negedge clk);
    req_addr = a; req_read = r; req_len = LW'(len);
    req_restart = rs; req_stop = sp; req_last = ls; req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_done(output logic e);
    while (!done) @(negedge clk);
    e = done_err;
  endtask

  task automatic settle();
    repeat (12) @(negedge clk);
  endtask

  task automatic t_reset();
    // R10 reset state
    chk(req_ready == 1'b1, "R10", "req_ready", req_ready, 1);
    chk(cmd_valid == 1'b0, "R10", "cmd_valid", cmd_valid, 0);
    chk(done == 1'b0, "R10", "done", done, 0);
    chk(rx_en == 1'b0, "R10", "rx_en", rx_en, 0);
  endtask

  task automatic t_single_write();
    int base; logic e;
    base = wp; en = 0;
    put_wr(8'h3C); put_wr(8'hA5);
    send_req(7'h50, 1'b0, 2, 1'b0, 1'b0, 1'b1);
    wait_done(e);
    chk(e == 1'b0, "R10", "done_err on success", e, 0);
    add_start(); add(aw(7'h50, 1'b0)); add(16'h0079); add(16'h014B); add_stop();
    chk(cmdlog[base] == 16'h0400, "R1", "start escape", cmdlog[base], 16'h0400);
    chk(cmdlog[base + 3] == 16'h0141, "R4", "address word", cmdlog[base + 3], 16'h0141);
    chk(cmdlog[base + 6] == 16'h0C00, "R3", "stop escape", cmdlog[base + 6], 16'h0C00);
    cmp_log("R5", base);
    settle();
  endtask

  task automatic t_write_then_read();
    int base, rc, dwb; logic e;
    @(negedge clk); inject = 1'b1;
    @(negedge clk); inject = 1'b0;
    base = wp; rc = rcnt; dwb = dw; en = 0;
    put_wr(8'h11);
    send_req(7'h2A, 1'b0, 1, 1'b0, 1'b0, 1'b0);
    send_req(7'h2A, 1'b1, 3, 1'b1, 1'b0, 1'b1);
    wait_done(e);
    chk(e == 1'b0, "R10", "done_err", e, 0);
    add_start(); add(aw(7'h2A, 1'b0)); add(16'h0023);
    add_rep(); add(aw(7'h2A, 1'b1)); add(16'h01FE); add(16'h01FE); add(16'h03FF); add_stop();
    chk(cmdlog[base + 5] == 16'h1000, "R2", "repeated start escape", cmdlog[base + 5], 16'h1000);
    chk(cmdlog[base + 14] == 16'h03FF, "R6", "last read word", cmdlog[base + 14], 16'h03FF);
    cmp_log("R2", base);
    chk((rcnt - rc) == 3, "R7", "read byte count", rcnt - rc, 3);
    for (int i = 0; i < 3; i++)
      chk(rbuf[(rc + i) % 64] == 8'(8'h30 + dwb + 3 + i), "R7", $sformatf("read byte %0d", i),
          rbuf[(rc + i) % 64], 8'(8'h30 + dwb + 3 + i));
    settle();
  endtask

  task automatic t_joined_writes();
    int base; logic e;
    base = wp; en = 0;
    put_wr(8'h01); put_wr(8'h02);
    send_req(7'h33, 1'b0, 1, 1'b0, 1'b0, 1'b0);
    send_req(7'h33, 1'b0, 1, 1'b0, 1'b0, 1'b1);
    wait_done(e);
    chk(e == 1'b0, "R10", "done_err", e, 0);
    add_start(); add(aw(7'h33, 1'b0)); add(16'h0003); add(16'h0005); add_stop();
    cmp_log("R3", base);
    settle();
  endtask

  task automatic t_nak_mid_write();
    int base, rec0; logic e; bit stray;
    base = wp; rec0 = rec_cnt;
    nak_at = dw + 2;
    put_wr(8'h10); put_wr(8'h20); put_wr(8'h30);
    put_wr(8'hE1); put_wr(8'hE2);
    send_req(7'h44, 1'b0, 3, 1'b0, 1'b0, 1'b0);
    send_req(7'h44, 1'b0, 2, 1'b0, 1'b0, 1'b1);
    wait_done(e);
    nak_at = -1;
    chk(e == 1'b1, "R9", "done_err after abort", e, 1);
    chk((rec_cnt - rec0) == 1, "R8", "recover pulses", rec_cnt - rec0, 1);
    chk(wptr == wcnt, "R9", "write bytes consumed", wptr, wcnt);
    en = 0; add_stop();
    for (int i = 0; i < 5; i++)
      chk(cmdlog[wp - 5 + i] == exp_w[i], "R8", $sformatf("stop word %0d", i),
          cmdlog[wp - 5 + i], exp_w[i]);
    stray = 1'b0;
    for (int i = base; i < wp; i++)
      if (cmdlog[i] == 16'h01C3 || cmdlog[i] == 16'h01C5) stray = 1'b1;
    chk(!stray, "R9", "aborted message words", stray, 0);
    chk(viol == 0, "R11", "pushes during error", viol, 0);
    settle();
  endtask

  task automatic t_read_after_error();
    int base, rc, dwb; logic e;
    base = wp; rc = rcnt; dwb = dw; en = 0;
    send_req(7'h12, 1'b1, 1, 1'b0, 1'b0, 1'b1);
    wait_done(e);
    chk(e == 1'b0, "R10", "done_err", e, 0);
    add_start(); add(aw(7'h12, 1'b1)); add(16'h03FF); add_stop();
    cmp_log("R1", base);
    chk((rcnt - rc) == 1, "R7", "read byte count", rcnt - rc, 1);
    chk(rbuf[rc % 64] == 8'(8'h30 + dwb + 1), "R6", "single read byte",
        rbuf[rc % 64], 8'(8'h30 + dwb + 1));
    settle();
  endtask

  task automatic t_nak_on_address();
    int rec0; logic e;
    rec0 = rec_cnt;
    nak_at = dw;
    put_wr(8'h77);
    send_req(7'h60, 1'b0, 1, 1'b0, 1'b0, 1'b1);
    wait_done(e);
    nak_at = -1;
    chk(e == 1'b1, "R8", "done_err on address NAK", e, 1);
    chk((rec_cnt - rec0) == 1, "R8", "recover pulses", rec_cnt - rec0, 1);
    chk(wptr == wcnt, "R5", "write byte consumed", wptr, wcnt);
    chk(cmdlog[wp - 5] == 16'h0C00, "R8", "stop after recovery", cmdlog[wp - 5], 16'h0C00);
    chk(viol == 0, "R11", "pushes during error", viol, 0);
    settle();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    tests++; fails++;
    $display("FAIL R10 watchdog: actual hung expected done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    tests = 0; fails = 0; wcnt = 0; nak_at = -1; inject = 1'b0;
    req_valid = 1'b0; req_addr = '0; req_read = 1'b0; req_len = '0;
    req_restart = 1'b0; req_stop = 1'b0; req_last = 1'b0;
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_single_write();
    t_write_then_read();
    t_joined_writes();
    t_nak_mid_write();
    t_read_after_error();
    t_nak_on_address();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule